// File: doc/BRIEF.md
# Open-Page DRAM Bank Controller

This block takes read requests that carry a flat address and turns each into a short sequence of DRAM commands on a command/address output. The flat address is split into bank, row and column fields. The controller keeps track of one open row for every bank and serves requests strictly in the order they arrive, with one request in flight at a time.

The command chosen depends on the state of the target bank. If the bank already has the requested row open, only a column read is sent. If the bank is idle, the row is activated first and then read. If a different row is open in that bank, that row is precharged, the new row is activated, and then the read is sent. Per-bank down-counters set the minimum gap between commands: activate-to-read, minimum active time and precharge recovery. A global counter keeps consecutive reads far enough apart that their bursts do not overlap.

Read data timing is given by a data-valid strobe. The strobe rises a fixed CAS latency after each read command and stays high for the burst length. Data moves on both clock edges, so each strobe cycle stands for two data beats.

Top module: `dram_bank_ctrl`

## Requirements
- R1: After reset, every bank is closed, cmd_o is NOP (0), rd_valid_o is low and req_ready_o is high.
- R2: req_addr_i is laid out as {bank, row, column}, with the column in the low COL_W bits and the bank in the top BANK_W bits. ACTIVATE carries the row on cmd_addr_o. READ carries the column. Both carry the bank on cmd_bank_o.
- R3: A request to a closed bank produces ACTIVATE (cmd 1) followed by READ (cmd 2) exactly T_RCD cycles later, when no other constraint holds it back.
- R4: A request whose row is already open in its bank produces a single READ and no ACTIVATE or PRECHARGE.
- R5: A request to an open bank with a different row produces PRECHARGE (cmd 3), then ACTIVATE of the new row, then READ. PRECHARGE comes no earlier than T_RAS cycles after that bank's ACTIVATE, and ACTIVATE comes no earlier than T_RP cycles after the PRECHARGE. Each command is issued as soon as its gap has elapsed.
- R6: rd_valid_o rises exactly T_CL cycles after a READ appears on cmd_o and stays high for BURST_CYC cycles, each cycle carrying two beats.
- R7: Two READs are at least BURST_CYC cycles apart. Back-to-back hits are spaced by exactly that amount, so their strobes form one unbroken run.
- R8: Requests are served in arrival order with at most one command per cycle. req_ready_o is low while an accepted request is still waiting for its READ.
- R9: Banks are independent. Activating a row in one bank leaves the row that is open in another bank open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Read request present |
| req_addr_i | input | BANK_W+ROW_W+COL_W | Flat address {bank, row, column} |
| req_ready_o | output | 1 | Request accepted on this cycle when valid |
| cmd_o | output | 2 | 0 NOP, 1 ACTIVATE, 2 READ, 3 PRECHARGE |
| cmd_bank_o | output | BANK_W | Bank addressed by the command |
| cmd_addr_o | output | max(ROW_W,COL_W) | Row for ACTIVATE, column for READ |
| rd_valid_o | output | 1 | Read data strobe, two beats per cycle |

## Verification
Each command leaves the block on a registered output. Commands are therefore measured against one another, not against the moment a request is accepted. The bench logs every non-NOP command with its cycle number and checks the gaps: T_RCD from ACTIVATE to READ, T_RAS from ACTIVATE to PRECHARGE, T_RP from PRECHARGE to ACTIVATE, and BURST_CYC between back-to-back READs. The data strobe is checked to start exactly T_CL cycles after its READ and to last for the expected number of cycles. All sampling happens on the falling edge, half a cycle after the registers update.

// File: rtl/dram_ctrl_pkg.sv
package dram_ctrl_pkg;
  typedef enum logic [1:0] {
    CMD_NOP = 2'd0,
    CMD_ACT = 2'd1,
    CMD_RD  = 2'd2,
    CMD_PRE = 2'd3
  } dram_cmd_e;
endpackage

// File: rtl/dram_bank_state.sv
module dram_bank_state #(
  parameter int ROW_W = 8,
  parameter int T_RCD = 9,
  parameter int T_RAS = 28,
  parameter int T_RP  = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             act_i,
  input  logic             pre_i,
  input  logic             rd_i,
  input  logic [ROW_W-1:0] act_row_i,
  output logic             open_o,
  output logic [ROW_W-1:0] row_o,
  output logic             rcd_ok_o,
  output logic             ras_ok_o,
  output logic             rp_ok_o
);
  localparam int RCD_W = $clog2(T_RCD + 1);
  localparam int RAS_W = $clog2(T_RAS + 1);
  localparam int RP_W  = $clog2(T_RP + 1);

  logic [RCD_W-1:0] rcd_cnt;
  logic [RAS_W-1:0] ras_cnt;
  logic [RP_W-1:0]  rp_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_o  <= 1'b0;
      row_o   <= '0;
      rcd_cnt <= '0;
      ras_cnt <= '0;
      rp_cnt  <= '0;
    end else begin
      if (act_i) begin
        open_o  <= 1'b1;
        row_o   <= act_row_i;
        rcd_cnt <= RCD_W'(T_RCD - 1);
        ras_cnt <= RAS_W'(T_RAS - 1);
      end else begin
        if (rcd_cnt != '0) rcd_cnt <= rcd_cnt - 1'b1;
        if (ras_cnt != '0) ras_cnt <= ras_cnt - 1'b1;
      end
      if (pre_i) begin
        open_o <= 1'b0;
        rp_cnt <= RP_W'(T_RP - 1);
      end else if (rp_cnt != '0) begin
        rp_cnt <= rp_cnt - 1'b1;
      end
    end
  end

  assign rcd_ok_o = (rcd_cnt == '0);
  assign ras_ok_o = (ras_cnt == '0);
  assign rp_ok_o  = (rp_cnt == '0);

  assert_act_opens_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i |=> open_o && (row_o == $past(act_row_i)));
  assert_act_closed_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i |-> !open_o && rp_ok_o);
  assert_pre_after_ras_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_i |-> open_o && ras_ok_o);
  assert_rd_after_rcd_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |-> open_o && rcd_ok_o);
endmodule

// File: rtl/dram_rd_timer.sv
module dram_rd_timer #(
  parameter int T_CL      = 9,
  parameter int BURST_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_issue_i,
  output logic rd_valid_o
);
  localparam int BC_W = $clog2(BURST_CYC + 1);

  logic [T_CL:0]   pipe_q;   // bit k set k cycles after READ shows on cmd_o
  logic [BC_W-1:0] burst_cnt;
  logic            start;

  assign start = pipe_q[T_CL];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pipe_q    <= '0;
      burst_cnt <= '0;
    end else begin
      pipe_q <= {pipe_q[T_CL-1:0], rd_issue_i};
      if (start)                burst_cnt <= BC_W'(BURST_CYC - 1);
      else if (burst_cnt != '0) burst_cnt <= burst_cnt - 1'b1;
    end
  end

  assign rd_valid_o = start || (burst_cnt != '0);

  assert_no_burst_overlap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |-> burst_cnt == '0);
endmodule

// File: rtl/dram_bank_ctrl.sv
module dram_bank_ctrl
  import dram_ctrl_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 8,
  parameter int COL_W     = 6,
  parameter int T_RCD     = 9,
  parameter int T_CL      = 9,
  parameter int T_RAS     = 28,
  parameter int T_RP      = 9,
  parameter int BURST_CYC = 4,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int ADDR_W   = BANK_W + ROW_W + COL_W,
  localparam int CA_W     = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              req_ready_o,
  output logic [1:0]        cmd_o,
  output logic [BANK_W-1:0] cmd_bank_o,
  output logic [CA_W-1:0]   cmd_addr_o,
  output logic              rd_valid_o
);
  localparam int RR_W = $clog2(BURST_CYC + 1);

  logic              head_v;
  logic [BANK_W-1:0] head_bank;
  logic [ROW_W-1:0]  head_row;
  logic [COL_W-1:0]  head_col;

  logic [NUM_BANKS-1:0] bk_open, bk_rcd_ok, bk_ras_ok, bk_rp_ok;
  logic [ROW_W-1:0]     bk_row [NUM_BANKS];
  logic [RR_W-1:0]      rr_cnt;

  logic hit, issue_act, issue_pre, issue_rd;
  dram_cmd_e cmd_q;

  assign req_ready_o = !head_v;

  assign hit       = bk_open[head_bank] && (bk_row[head_bank] == head_row);
  assign issue_act = head_v && !bk_open[head_bank] && bk_rp_ok[head_bank];
  assign issue_pre = head_v && bk_open[head_bank] && !hit && bk_ras_ok[head_bank];
  assign issue_rd  = head_v && hit && bk_rcd_ok[head_bank] && (rr_cnt == '0);

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic sel;
    assign sel = (head_bank == BANK_W'(g));
    dram_bank_state #(
      .ROW_W(ROW_W), .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RP(T_RP)
    ) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .act_i     (issue_act && sel),
      .pre_i     (issue_pre && sel),
      .rd_i      (issue_rd && sel),
      .act_row_i (head_row),
      .open_o    (bk_open[g]),
      .row_o     (bk_row[g]),
      .rcd_ok_o  (bk_rcd_ok[g]),
      .ras_ok_o  (bk_ras_ok[g]),
      .rp_ok_o   (bk_rp_ok[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_v    <= 1'b0;
      head_bank <= '0;
      head_row  <= '0;
      head_col  <= '0;
      rr_cnt    <= '0;
    end else begin
      if (issue_rd) begin
        head_v <= 1'b0;
      end else if (req_valid_i && req_ready_o) begin
        head_v                          <= 1'b1;
        {head_bank, head_row, head_col} <= req_addr_i;
      end
      if (issue_rd)           rr_cnt <= RR_W'(BURST_CYC - 1);
      else if (rr_cnt != '0)  rr_cnt <= rr_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q      <= CMD_NOP;
      cmd_bank_o <= '0;
      cmd_addr_o <= '0;
    end else begin
      cmd_q      <= CMD_NOP;
      cmd_bank_o <= head_bank;
      cmd_addr_o <= '0;
      if (issue_act) begin
        cmd_q      <= CMD_ACT;
        cmd_addr_o <= CA_W'(head_row);
      end else if (issue_pre) begin
        cmd_q      <= CMD_PRE;
      end else if (issue_rd) begin
        cmd_q      <= CMD_RD;
        cmd_addr_o <= CA_W'(head_col);
      end
    end
  end

  assign cmd_o = cmd_q;

  dram_rd_timer #(.T_CL(T_CL), .BURST_CYC(BURST_CYC)) u_rd_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_issue_i (issue_rd),
    .rd_valid_o (rd_valid_o)
  );

  assert_hold_head_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    head_v && !issue_rd |=> head_v && $stable(head_row) && $stable(head_bank));
  assert_hit_reads_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_rd |=> cmd_o == 2'd2);
endmodule

// File: tb/dram_bank_ctrl_tb_top.sv
module dram_bank_ctrl_tb_top;
  localparam int NB = 4, RW = 8, CW = 6, BW = 2, AW = 16, CAW = 8;
  localparam int T_RCD = 9, T_CL = 9, T_RAS = 28, T_RP = 9, BC = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic req_ready;
  logic [1:0] cmd;
  logic [BW-1:0] cmd_bank;
  logic [CAW-1:0] cmd_addr;
  logic rd_valid;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int ev_n = 0;
  int ev_cmd [32];
  int ev_bank[32];
  int ev_addr[32];
  int ev_cyc [32];
  int v_first = -1, v_cnt = 0;
  bit logging = 1'b0;

  always #2.5 clk = ~clk;

  dram_bank_ctrl #(
    .NUM_BANKS(NB), .ROW_W(RW), .COL_W(CW), .T_RCD(T_RCD), .T_CL(T_CL),
    .T_RAS(T_RAS), .T_RP(T_RP), .BURST_CYC(BC)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_addr_i(req_addr),
    .req_ready_o(req_ready), .cmd_o(cmd), .cmd_bank_o(cmd_bank),
    .cmd_addr_o(cmd_addr), .rd_valid_o(rd_valid)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (logging) begin
      if (cmd != 2'd0 && ev_n < 32) begin
        ev_cmd[ev_n]  = int'(cmd);
        ev_bank[ev_n] = int'(cmd_bank);
        ev_addr[ev_n] = int'(cmd_addr);
        ev_cyc[ev_n]  = cyc;
        ev_n++;
      end
      if (rd_valid) begin
        if (v_first < 0) v_first = cyc;
        v_cnt++;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_log();
    ev_n = 0; v_first = -1; v_cnt = 0; logging = 1'b1;
  endtask

  task automatic send(input int bank, input int row, input int col);
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = {BW'(bank), RW'(row), CW'(col)};
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (70) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 cmd", int'(cmd), 0);
    chk("R1 rd_valid", int'(rd_valid), 0);
    chk("R1 ready", int'(req_ready), 1);
  endtask

  task automatic t_closed_bank();
    clear_log();
    send(1, 8'h12, 5);
    settle();
    chk("R3 events", ev_n, 2);
    chk("R3 act cmd", ev_cmd[0], 1);
    chk("R2 act bank", ev_bank[0], 1);
    chk("R2 act row", ev_addr[0], 8'h12);
    chk("R3 rd cmd", ev_cmd[1], 2);
    chk("R2 rd col", ev_addr[1], 5);
    chk("R3 act to rd", ev_cyc[1] - ev_cyc[0], T_RCD);
    chk("R6 cas latency", v_first - ev_cyc[1], T_CL);
    chk("R6 burst length", v_cnt, BC);
  endtask

  task automatic t_row_hit();
    clear_log();
    send(1, 8'h12, 7);
    settle();
    chk("R4 events", ev_n, 1);
    chk("R4 rd only", ev_cmd[0], 2);
    chk("R4 col", ev_addr[0], 7);
    chk("R6 burst length", v_cnt, BC);
  endtask

  task automatic t_row_miss();
    clear_log();
    send(2, 1, 0);
    chk("R8 ready low while pending", int'(req_ready), 0);
    send(2, 2, 1);
    settle();
    chk("R5 events", ev_n, 5);
    chk("R8 order act", ev_cmd[0], 1);
    chk("R8 order rd", ev_cmd[1], 2);
    chk("R5 pre cmd", ev_cmd[2], 3);
    chk("R5 pre bank", ev_bank[2], 2);
    chk("R5 act cmd", ev_cmd[3], 1);
    chk("R5 new row", ev_addr[3], 2);
    chk("R5 rd cmd", ev_cmd[4], 2);
    chk("R5 act to pre", ev_cyc[2] - ev_cyc[0], T_RAS);
    chk("R5 pre to act", ev_cyc[3] - ev_cyc[2], T_RP);
    chk("R3 act to rd", ev_cyc[4] - ev_cyc[3], T_RCD);
  endtask

  task automatic t_banks_and_spacing();
    clear_log();
    send(0, 3, 1);
    send(3, 4, 2);
    settle();
    chk("R9 two acts", ev_n, 4);
    clear_log();
    send(0, 3, 9);
    send(0, 3, 10);
    settle();
    chk("R9 bank0 still open", ev_n, 2);
    chk("R9 rd0", ev_cmd[0], 2);
    chk("R7 rd1", ev_cmd[1], 2);
    chk("R2 rd1 col", ev_addr[1], 10);
    chk("R7 rd spacing", ev_cyc[1] - ev_cyc[0], BC);
    chk("R6 first data", v_first - ev_cyc[0], T_CL);
    chk("R7 joined bursts", v_cnt, 2 * BC);
    clear_log();
    send(3, 4, 3);
    settle();
    chk("R9 bank3 hit", ev_n, 1);
    chk("R9 bank3 rd", ev_cmd[0], 2);
    chk("R9 bank3 id", ev_bank[0], 3);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_closed_bank();
    t_row_hit();
    t_row_miss();
    t_banks_and_spacing();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule